// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits at the register window of a network controller and sorts every host access into one of three outcomes. An access can be served by a 16-byte station-address PROM held inside the block, passed on to a downstream register port, or refused. Two host front ends feed it. One is an I/O-port path that splits the window by offset. The other is a memory-mapped path that splits it by address bit 4. Each front end presents a read strobe, a write strobe, a byte address, a size code and 32 bits of write data.

On the I/O-port path, the sizes and alignments that may reach the PROM depend on a dword-I/O mode input. The memory-mapped path reads or writes consecutive PROM bytes at any offset, and it ignores that mode. Multi-byte values are assembled little-endian. A PROM write only changes the contents while a write-enable input is high. A refused read returns all ones across the access width. Read data is registered and appears one cycle after the strobe. On reset the PROM is loaded from a parameter.

Top module: `prom_addr_decoder`

## Requirements
- R1: After reset, both read-data outputs are zero and PROM byte i holds bits 8i+7..8i of parameter PROM_INIT.
- R2: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Byte k of a multi-byte value is PROM byte (base+k) mod 16 and sits on bus bits 8k+7..8k. Unused upper bus bits read as zero.
- R3: On the I/O path with the dword mode input low, an offset below 16 reaches the PROM for a 1-byte access at any offset or for a 2-byte access at an even offset.
- R4: On the I/O path with the dword mode input high, the only access below offset 16 that reaches the PROM is a 4-byte access at an offset that is a multiple of 4.
- R5: On the I/O path, an access below offset 16 that breaks the R3/R4 rules has no effect. If it is a read, it returns all ones over its width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R6: A PROM write stores its bytes only while prom_wr_en is high. Otherwise the PROM is unchanged. Reads do not depend on prom_wr_en.
- R7: On the I/O path, a 2-byte or 4-byte access at offset 16 or above drives the register port in the same cycle with the full offset, reg_dword high for 4 bytes, and the write data. Read data is reg_rdata limited to the access width.
- R8: On the I/O path, a 1-byte access at offset 16 or above raises no register-port strobe. If it is a read, it returns 0xFF.
- R9: On the memory-mapped path with address bit 4 clear, any 1, 2 or 4-byte access reaches the PROM at the low 4 address bits, whatever the dword mode and alignment. Byte indices wrap modulo 16.
- R10: On the memory-mapped path with address bit 4 set, 2-byte and 4-byte accesses go to the register port at the low 4 address bits. A 1-byte access raises no strobe and reads 0xFF.
- R11: Read data is updated at the clock edge that samples the read strobe and then holds. A PROM write takes effect at that same edge, so a read in the same cycle sees the old contents.
- R12: Size code 3 is reserved. Such an access has no effect and, if it is a read, returns 0xFFFFFFFF.
- R13: When both front ends strobe in the same cycle, the I/O access is served. The memory-mapped access is dropped, and a memory-mapped read returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dword_mode | input | 1 | Dword-I/O mode for the I/O path PROM rules |
| prom_wr_en | input | 1 | PROM write enable |
| io_rd | input | 1 | I/O path read strobe |
| io_wr | input | 1 | I/O path write strobe |
| io_addr | input | IO_AW | I/O path byte offset |
| io_size | input | 2 | I/O path size code |
| io_wdata | input | 32 | I/O path write data |
| io_rdata | output | 32 | I/O path read data, one cycle after strobe |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_wr | input | 1 | Memory-mapped write strobe |
| mm_addr | input | MM_AW | Memory-mapped byte address |
| mm_size | input | 2 | Memory-mapped size code |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rdata | output | 32 | Memory-mapped read data, one cycle after strobe |
| reg_rd | output | 1 | Register port read strobe |
| reg_wr | output | 1 | Register port write strobe |
| reg_addr | output | IO_AW | Register port offset |
| reg_dword | output | 1 | Register port access is 4 bytes (else 2) |
| reg_wdata | output | 32 | Register port write data |
| reg_rdata | input | 32 | Register port read data, same cycle |

## Verification
The bench targets the alignment edges of the I/O PROM window under both settings of dword mode. A decoder that checks the wrong mode would return PROM bytes where all ones are due, or the reverse. It also runs memory-mapped dword reads at offsets 13 to 15: a design without the modulo-16 wrap would read or write the wrong bytes. Writes while prom_wr_en is low are followed by readback, which catches an ungated PROM. Byte accesses in the register half are checked to raise no strobe. Simultaneous strobes on both front ends show whether the memory-mapped access was dropped and answered with all ones, or whether it corrupted the PROM.

// File: rtl/prom_dec_pkg.sv
package prom_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic        prom_hit;
    logic        reg_hit;
    logic [3:0]  lanes;
    logic [31:0] miss_val;
  } dec_t;

  function automatic logic [3:0] size_lanes(acc_size_e s);
    case (s)
      SZ_BYTE: return 4'b0001;
      SZ_HALF: return 4'b0011;
      SZ_WORD: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] size_ones(acc_size_e s);
    case (s)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(logic [3:0] l);
    return {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
  endfunction

endpackage

// File: rtl/prom_io_front.sv
module prom_io_front
  import prom_dec_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          dword_mode,
  output dec_t          dec
);
  localparam logic [AW-1:0] PromTop = AW'(16);

  acc_size_e sz;
  logic      legal;

  always_comb begin
    sz           = acc_size_e'(size);
    legal        = 1'b0;
    dec          = '0;
    dec.lanes    = size_lanes(sz);
    dec.miss_val = size_ones(sz);
    if (addr < PromTop) begin
      if (!dword_mode) begin
        legal = (sz == SZ_BYTE) || ((sz == SZ_HALF) && !addr[0]);
      end else begin
        legal = (sz == SZ_WORD) && (addr[1:0] == 2'b00);
      end
      dec.prom_hit = legal;
    end else begin
      dec.reg_hit = (sz == SZ_HALF) || (sz == SZ_WORD);
    end
  end
endmodule

// File: rtl/prom_mm_front.sv
module prom_mm_front
  import prom_dec_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output dec_t          dec
);
  acc_size_e sz;

  always_comb begin
    sz           = acc_size_e'(size);
    dec          = '0;
    dec.lanes    = size_lanes(sz);
    dec.miss_val = size_ones(sz);
    dec.prom_hit = !addr[4] && (sz != SZ_RSVD);
    dec.reg_hit  = addr[4] && ((sz == SZ_HALF) || (sz == SZ_WORD));
  end
endmodule

// File: rtl/prom_store.sv
module prom_store #(
  parameter int           BYTES = 16,
  parameter int           LANES = 4,
  parameter logic [127:0] INIT  = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(BYTES)-1:0] base,
  input  logic [LANES-1:0]         lanes,
  input  logic [8*LANES-1:0]       wdata,
  output logic [8*LANES-1:0]       rd_word
);
  localparam int IW = $clog2(BYTES);

  logic [7:0] mem_q [BYTES];
  logic [7:0] mem_d [BYTES];

  always_comb begin
    for (int i = 0; i < BYTES; i++) mem_d[i] = mem_q[i];
    if (wr_en) begin
      for (int k = 0; k < LANES; k++) begin
        if (lanes[k]) mem_d[IW'(base + IW'(k))] = wdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= INIT[8*i +: 8];
    end else if (wr_en) begin
      for (int i = 0; i < BYTES; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_word[8*k +: 8] = mem_q[IW'(base + IW'(k))];
  end
endmodule

// File: rtl/prom_addr_decoder.sv
module prom_addr_decoder
  import prom_dec_pkg::*;
#(
  parameter int           IO_AW     = 5,
  parameter int           MM_AW     = 5,
  parameter logic [127:0] PROM_INIT = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dword_mode,
  input  logic             prom_wr_en,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  input  logic             mm_rd,
  input  logic             mm_wr,
  input  logic [MM_AW-1:0] mm_addr,
  input  logic [1:0]       mm_size,
  input  logic [31:0]      mm_wdata,
  output logic [31:0]      mm_rdata,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic [IO_AW-1:0] reg_addr,
  output logic             reg_dword,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata
);
  localparam int PromBytes = 16;
  localparam int IdxW      = $clog2(PromBytes);

  dec_t        io_dec, mm_dec, win_dec;
  logic        io_act, mm_act, any_act;
  logic        win_rd, win_wr;
  logic [IdxW-1:0] win_base;
  logic [31:0] win_wdata, prom_word, read_val;
  logic        prom_we;
  logic [31:0] io_rdata_d, io_rdata_q, mm_rdata_d, mm_rdata_q;

  prom_io_front #(.AW(IO_AW)) u_io (
    .addr(io_addr), .size(io_size), .dword_mode(dword_mode), .dec(io_dec)
  );

  prom_mm_front #(.AW(MM_AW)) u_mm (
    .addr(mm_addr), .size(mm_size), .dec(mm_dec)
  );

  // I/O front end wins a same-cycle collision
  always_comb begin
    io_act    = io_rd || io_wr;
    mm_act    = (mm_rd || mm_wr) && !io_act;
    any_act   = io_act || mm_act;
    win_dec   = io_act ? io_dec : mm_dec;
    win_rd    = io_act ? io_rd : (mm_act && mm_rd);
    win_wr    = io_act ? io_wr : (mm_act && mm_wr);
    win_base  = io_act ? io_addr[IdxW-1:0] : mm_addr[IdxW-1:0];
    win_wdata = io_act ? io_wdata : mm_wdata;
    prom_we   = any_act && win_wr && win_dec.prom_hit && prom_wr_en;
  end

  prom_store #(.BYTES(PromBytes), .LANES(4), .INIT(PROM_INIT)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(prom_we), .base(win_base),
    .lanes(win_dec.lanes), .wdata(win_wdata), .rd_word(prom_word)
  );

  always_comb begin
    reg_rd    = any_act && win_rd && win_dec.reg_hit;
    reg_wr    = any_act && win_wr && win_dec.reg_hit;
    reg_addr  = io_act ? io_addr : IO_AW'(mm_addr[IdxW-1:0]);
    reg_dword = (win_dec.lanes == 4'b1111);
    reg_wdata = win_wdata;
    if (win_dec.prom_hit)     read_val = prom_word & lane_mask(win_dec.lanes);
    else if (win_dec.reg_hit) read_val = reg_rdata & lane_mask(win_dec.lanes);
    else                      read_val = win_dec.miss_val;
  end

  always_comb begin
    io_rdata_d = io_rdata_q;
    mm_rdata_d = mm_rdata_q;
    if (io_rd) io_rdata_d = read_val;
    if (mm_rd) mm_rdata_d = mm_act ? read_val : 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata_q <= '0;
      mm_rdata_q <= '0;
    end else begin
      if (io_rd) io_rdata_q <= io_rdata_d;
      if (mm_rd) mm_rdata_q <= mm_rdata_d;
    end
  end

  assign io_rdata = io_rdata_q;
  assign mm_rdata = mm_rdata_q;
endmodule

// File: rtl/prom_addr_decoder_chk.sv
module prom_addr_decoder_chk #(
  parameter int IO_AW = 5,
  parameter int MM_AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dword_mode,
  input logic             io_rd,
  input logic             io_wr,
  input logic [IO_AW-1:0] io_addr,
  input logic [1:0]       io_size,
  input logic [31:0]      io_rdata,
  input logic             mm_rd,
  input logic             mm_wr,
  input logic [MM_AW-1:0] mm_addr,
  input logic [1:0]       mm_size,
  input logic [31:0]      mm_rdata,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [IO_AW-1:0] reg_addr,
  input logic             reg_dword
);
  localparam logic [IO_AW-1:0] Top = IO_AW'(16);

  AST_IO_BYTE_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_addr >= Top && io_size == 2'd0) |-> !(reg_rd || reg_wr)); // R8

  AST_IO_WORD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr >= Top && io_size == 2'd2) |-> (reg_rd && reg_addr == io_addr && reg_dword)); // R7

  AST_MM_HALF_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_rd && !io_rd && !io_wr && mm_addr[4] && mm_size == 2'd1)
      |-> (reg_rd && reg_addr == IO_AW'(mm_addr[3:0]) && !reg_dword)); // R10

  AST_DWORD_MODE_BYTE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr < Top && dword_mode && io_size == 2'd0) |=> (io_rdata == 32'h0000_00FF)); // R5

  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_size == 2'd3) |=> (io_rdata == 32'hFFFF_FFFF)); // R12

  AST_COLLIDE_MM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && mm_rd) |=> (mm_rdata == 32'hFFFF_FFFF)); // R13

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata)); // R11
endmodule

bind prom_addr_decoder prom_addr_decoder_chk #(.IO_AW(IO_AW), .MM_AW(MM_AW)) u_chk (.*);

// File: tb/prom_addr_decoder_test.sv
module prom_addr_decoder_test;
  localparam int           CLK_PERIOD = 10;
  localparam logic [127:0] INIT = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        dword_mode = 1'b0, prom_wr_en = 1'b0;
  logic        io_rd = 1'b0, io_wr = 1'b0, mm_rd = 1'b0, mm_wr = 1'b0;
  logic [4:0]  io_addr = '0, mm_addr = '0, reg_addr;
  logic [1:0]  io_size = '0, mm_size = '0;
  logic [31:0] io_wdata = '0, mm_wdata = '0, reg_rdata = '0;
  logic [31:0] io_rdata, mm_rdata, reg_wdata;
  logic        reg_rd, reg_wr, reg_dword;

  int checks = 0, errors = 0;
  logic [7:0]  model [16];
  logic [31:0] exp_io = '0, exp_mm = '0;

  prom_addr_decoder #(.IO_AW(5), .MM_AW(5), .PROM_INIT(INIT)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ones(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  task automatic acc(input logic ir, iw, input logic [4:0] ia, input logic [1:0] isz, input logic [31:0] id,
                     input logic mr, mw, input logic [4:0] ma, input logic [1:0] msz, input logic [31:0] md,
                     input string tag);
    logic io_act, mm_act, wrd, wwr, prom_ok, reg_ok;
    logic [4:0]  wa, eaddr;
    logic [1:0]  ws;
    logic [31:0] wd, rr, rv, mask;
    int n;
    rr     = $urandom;
    io_act = ir | iw;
    mm_act = (mr | mw) & !io_act;
    wa  = io_act ? ia : ma;
    ws  = io_act ? isz : msz;
    wd  = io_act ? id : md;
    wrd = io_act ? ir : (mm_act & mr);
    wwr = io_act ? iw : (mm_act & mw);
    n   = nbytes(ws);
    mask = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
    prom_ok = 1'b0; reg_ok = 1'b0;
    if (ws != 2'd3) begin
      if (io_act) begin
        if (wa < 5'd16) prom_ok = dword_mode ? (ws == 2'd2 && wa[1:0] == 2'b00)
                                              : (ws == 2'd0 || (ws == 2'd1 && !wa[0]));
        else            reg_ok = (ws != 2'd0);
      end else begin
        if (!wa[4]) prom_ok = 1'b1;
        else        reg_ok  = (ws != 2'd0);
      end
    end
    eaddr = io_act ? wa : {1'b0, wa[3:0]};
    rv = '0;
    if (prom_ok) for (int k = 0; k < n; k++) rv[8*k +: 8] = model[(wa[3:0] + k) % 16];
    else if (reg_ok) rv = rr & mask;
    else rv = ones(ws);

    @(negedge clk);
    io_rd = ir; io_wr = iw; io_addr = ia; io_size = isz; io_wdata = id;
    mm_rd = mr; mm_wr = mw; mm_addr = ma; mm_size = msz; mm_wdata = md;
    reg_rdata = rr;
    #1;
    check(reg_rd == ((io_act | mm_act) & wrd & reg_ok), {tag, " R7/R8/R10 reg_rd"}, 32'(reg_rd), 32'((io_act | mm_act) & wrd & reg_ok));
    check(reg_wr == ((io_act | mm_act) & wwr & reg_ok), {tag, " R7/R8/R10 reg_wr"}, 32'(reg_wr), 32'((io_act | mm_act) & wwr & reg_ok));
    if (reg_ok && (wrd | wwr)) begin
      check(reg_addr == eaddr, {tag, " R7/R10 reg_addr"}, 32'(reg_addr), 32'(eaddr));
      check(reg_dword == (ws == 2'd2), {tag, " R7 reg_dword"}, 32'(reg_dword), 32'(ws == 2'd2));
      if (wwr) check(reg_wdata == wd, {tag, " R7 reg_wdata"}, reg_wdata, wd);
    end
    if (ir) exp_io = rv;
    if (mr) exp_mm = mm_act ? rv : 32'hFFFF_FFFF;
    @(negedge clk);
    check(io_rdata == exp_io, {tag, " R2/R3/R4/R5/R11/R12 io_rdata"}, io_rdata, exp_io);
    check(mm_rdata == exp_mm, {tag, " R9/R11/R13 mm_rdata"}, mm_rdata, exp_mm);
    if (prom_ok && wwr && prom_wr_en)
      for (int k = 0; k < n; k++) model[(wa[3:0] + k) % 16] = wd[8*k +: 8];
    io_rd = 0; io_wr = 0; mm_rd = 0; mm_wr = 0;
  endtask

  task automatic io(input logic r, w, input logic [4:0] a, input logic [1:0] s, input logic [31:0] d, input string t);
    acc(r, w, a, s, d, 1'b0, 1'b0, 5'd0, 2'd0, 32'd0, t);
  endtask

  task automatic mm(input logic r, w, input logic [4:0] a, input logic [1:0] s, input logic [31:0] d, input string t);
    acc(1'b0, 1'b0, 5'd0, 2'd0, 32'd0, r, w, a, s, d, t);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = INIT[8*i +: 8];
    #(3 * CLK_PERIOD) rst_n = 1'b1;
    @(negedge clk);
    check(io_rdata == 0, "R1 io_rdata reset", io_rdata, 0);
    check(mm_rdata == 0, "R1 mm_rdata reset", mm_rdata, 0);
    for (int a = 0; a < 16; a += 4) mm(1, 0, 5'(a), 2'd2, 0, "R1 init contents");
    // R3 byte/odd half with dword mode off
    io(1, 0, 5'd7, 2'd0, 0, "R3 byte");
    io(1, 0, 5'd6, 2'd1, 0, "R3 even half");
    io(1, 0, 5'd5, 2'd1, 0, "R5 odd half");
    io(1, 0, 5'd4, 2'd2, 0, "R5 word mode off");
    // R4 dword mode
    dword_mode = 1;
    io(1, 0, 5'd8, 2'd2, 0, "R4 aligned word");
    io(1, 0, 5'd6, 2'd2, 0, "R5 misaligned word");
    io(1, 0, 5'd2, 2'd1, 0, "R5 half in dword mode");
    mm(1, 0, 5'd3, 2'd1, 0, "R9 mm ignores dword mode");
    // R6 write gating
    prom_wr_en = 0;
    io(0, 1, 5'd0, 2'd2, 32'hDEAD_BEEF, "R6 write blocked");
    io(1, 0, 5'd0, 2'd2, 0, "R6 readback blocked");
    prom_wr_en = 1;
    io(0, 1, 5'd0, 2'd2, 32'hDEAD_BEEF, "R6 write enabled");
    io(1, 0, 5'd0, 2'd2, 0, "R6 readback");
    // R9 wrap
    mm(0, 1, 5'd14, 2'd2, 32'h1122_3344, "R9 wrap write");
    mm(1, 0, 5'd15, 2'd2, 0, "R9 wrap read");
    mm(1, 0, 5'd13, 2'd2, 0, "R9 wrap read 13");
    // R7/R8/R10 register half
    io(1, 0, 5'd18, 2'd1, 0, "R7 half");
    io(0, 1, 5'd20, 2'd2, 32'hCAFE_F00D, "R7 word write");
    io(1, 0, 5'd17, 2'd0, 0, "R8 byte read");
    io(0, 1, 5'd17, 2'd0, 32'h55, "R8 byte write");
    mm(1, 0, 5'd22, 2'd2, 0, "R10 word");
    mm(1, 0, 5'd19, 2'd0, 0, "R10 byte");
    // R12 reserved
    io(1, 0, 5'd0, 2'd3, 0, "R12 io reserved");
    mm(0, 1, 5'd0, 2'd3, 32'h0, "R12 mm reserved write");
    mm(1, 0, 5'd0, 2'd2, 0, "R12 no effect");
    // R13 collision
    acc(1, 0, 5'd1, 2'd0, 0, 1, 0, 5'd4, 2'd2, 0, "R13 both read");
    acc(0, 1, 5'd20, 2'd1, 32'h7777, 0, 1, 5'd8, 2'd2, 32'h9999_9999, "R13 both write");
    mm(1, 0, 5'd8, 2'd2, 0, "R13 mm write dropped");
    // R11 hold across write
    io(0, 1, 5'd3, 2'd0, 32'hAB, "R11 hold");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic pick;
      dword_mode = 1'($urandom);
      prom_wr_en = 1'($urandom);
      pick = 1'($urandom);
      if ($urandom % 8 == 0)
        acc(1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom), $urandom,
            1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom), $urandom, "rand both");
      else if (pick)
        io(1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom), $urandom, "rand io");
      else
        mm(1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom), $urandom, "rand mm");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule